// File: doc/BRIEF.md
# Idle-Timeout Device Shutdown Controller

This block manages the power state of a single device. It watches a busy/idle activity signal and a service-request input. Once the device has stayed idle for a timeout τ, it steps through a shutdown interval into sleep. It stays asleep until work arrives, then runs a wake-up interval before it reports the device ready again. The shutdown and wake-up intervals are fixed-length states. Activity that shows up during them does not cut them short: it is remembered and acted on after the interval ends.

The timeout τ comes from one of three sources, chosen by a mode input:
- a fixed value supplied on a configuration port;
- the device's break-even time, supplied as a precomputed cycle count;
- an adaptive register that is retuned at the end of every idle period, based on the measured length of that period.

In adaptive mode, τ stays between the break-even time and a configured ceiling. This means a shutdown is never tried for an idle stretch too short to pay back its energy cost. The value in use is always visible on `tau_o`.

Top module: `idle_timeout_pm`

## Requirements
- R1: During reset and right after it, the power state is WORK (code 0), ready is high and pending is low.
- R2: Power-state codes are WORK=0, IDLE=1, SHUTDOWN=2, SLEEP=3, WAKEUP=4.
  - In WORK, an edge with busy and request both low moves the block to IDLE.
  - SHUTDOWN starts at the edge that samples busy and request low for the τ-th consecutive time, counting the edge that left WORK. IDLE therefore lasts τ−1 cycles.
- R3: In IDLE, an edge that samples busy or request high returns the block to WORK. That idle period ends there, and its length is the number of cycles spent in IDLE.
- R4: SHUTDOWN lasts max(shutdown latency, 1) cycles and then always enters SLEEP. Busy or request during SHUTDOWN does not abort it.
- R5: SLEEP holds while pending is low. With pending high, the next edge enters WAKEUP. WAKEUP lasts max(wake latency, 1) cycles and then enters WORK.
- R6: Ready is high exactly while the power state is WORK.
- R7: A single pending flag is set by busy or request sampled in any state other than WORK, and cleared by an edge in WORK. Several requests while not ready cause only one wake-up.
- R8: Mode codes: 0 is fixed, 1 is adaptive, 2 is device-dependent.
  - Fixed mode: τ = max(configured timeout, 2).
  - Device-dependent mode: τ = max(break-even, 2).
- R9: In adaptive mode, an idle period shorter than τ doubles τ. The result is capped at the ceiling, where the ceiling is raised to the floor if it is set below it.
- R10: In adaptive mode, an idle period that ends in a wake-up is handled as follows:
  - Its length L is the number of cycles spent in IDLE, SHUTDOWN and SLEEP.
  - If L ≥ 2τ, τ is halved, but never below the floor max(break-even, 2).
  - If τ ≤ L < 2τ, τ is unchanged.
- R11: While the mode is not adaptive, the adaptive register tracks max(configured timeout, 2). Switching into adaptive mode therefore starts from that value.
- R12: Mode code 3 behaves as fixed mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| busy_i | input | 1 | Device activity (1 = busy) |
| req_i | input | 1 | Service request |
| mode_i | input | 2 | Timeout source: 0 fixed, 1 adaptive, 2 device-dependent, 3 fixed |
| cfg_tau_i | input | CNT_W | Configured timeout in cycles |
| cfg_tbe_i | input | CNT_W | Break-even time in cycles |
| cfg_tau_max_i | input | CNT_W | Adaptive timeout ceiling |
| cfg_tsd_i | input | LAT_W | Shutdown latency in cycles |
| cfg_twu_i | input | LAT_W | Wake-up latency in cycles |
| pstate_o | output | 3 | Power state code |
| ready_o | output | 1 | Device may be served (WORK only) |
| pending_o | output | 1 | Request held while not ready |
| tau_o | output | CNT_W | Timeout currently in effect |

## Verification
The hardest situation to reach is an adaptive halving. It needs an idle stretch that survives τ−1 idle cycles, a full shutdown and enough sleep to reach twice τ, followed by exactly one wake-up request. Directed sequences raise τ to the ceiling with short idle bursts, then walk it down to the break-even floor with long sleeps. Activity is injected during shutdown and wake-up to show those intervals run to completion. Seeded random bursts of busy, idle and request activity then run with configuration changes in every mode, checked cycle by cycle against a bench model.

// File: rtl/pm_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the idle-timeout power controller.
// Assumes: state and mode codes are visible at the ports and must stay stable.
package pm_pkg;

    typedef enum logic [2:0] {
        PS_WORK  = 3'd0,
        PS_IDLE  = 3'd1,
        PS_SHUT  = 3'd2,
        PS_SLEEP = 3'd3,
        PS_WAKE  = 3'd4
    } pstate_e;

    typedef enum logic [1:0] {
        MODE_FIXED  = 2'd0,
        MODE_ADAPT  = 2'd1,
        MODE_DEVDEP = 2'd2,
        MODE_RSVD   = 2'd3
    } mode_e;

endpackage

// File: rtl/pm_idle_meter.sv
`timescale 1ns/1ps
// Module: measures the length of the current idle period in cycles.
// Assumes: start and run are never high together; the count saturates.
module pm_idle_meter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         run,
    output logic [W-1:0] len
);
    localparam logic [W-1:0] SAT = {W{1'b1}};

    // Purpose: restart at one on idle entry, otherwise count up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len <= '0;
        end else if (start) begin
            len <= W'(1);
        end else if (run && len != SAT) begin
            len <= len + W'(1);
        end
    end
endmodule

// File: rtl/pm_latency_timer.sv
`timescale 1ns/1ps
// Module: down-counter that times a transition interval.
// Assumes: load on the entry edge; a zero latency is treated as one cycle.
module pm_latency_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         last
);
    logic [W-1:0] cnt;

    // Purpose: load the interval length, then count it down to one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= W'(1);
        end else if (load) begin
            cnt <= (load_val == '0) ? W'(1) : load_val;
        end else if (tick && cnt > W'(1)) begin
            cnt <= cnt - W'(1);
        end
    end

    // Purpose: flag the final cycle of the interval.
    always_comb last = (cnt <= W'(1));
endmodule

// File: rtl/pm_timeout_adapt.sv
`timescale 1ns/1ps
// Module: selects the timeout in effect and retunes the adaptive value.
// Assumes: end_valid pulses once per finished idle period with its length.
// Floor is max(break-even, 2); a ceiling below the floor is raised to it.
module pm_timeout_adapt
    import pm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   mode,
    input  logic [W-1:0] cfg_tau,
    input  logic [W-1:0] cfg_tbe,
    input  logic [W-1:0] cfg_max,
    input  logic         end_valid,
    input  logic [W-1:0] end_len,
    output logic [W-1:0] tau_eff
);
    localparam logic [W-1:0] FLOOR = W'(2);

    mode_e        mode_q;
    logic [W-1:0] tau_reg;
    logic [W-1:0] lo, hi, fixed_tau, adapt_eff, next_tau;
    logic [W:0]   dbl, twice;
    logic [W-1:0] dbl_c, hlf, hlf_c;
    logic         short_idle, long_idle;

    // Purpose: derive bounds and the fixed-mode value from configuration.
    always_comb begin
        mode_q    = mode_e'(mode);
        lo        = (cfg_tbe > FLOOR) ? cfg_tbe : FLOOR;
        hi        = (cfg_max < lo) ? lo : cfg_max;
        fixed_tau = (cfg_tau > FLOOR) ? cfg_tau : FLOOR;
        adapt_eff = (tau_reg < lo) ? lo : ((tau_reg > hi) ? hi : tau_reg);
    end

    // Purpose: compute the retuned adaptive timeout from the last idle length.
    always_comb begin
        dbl        = {adapt_eff, 1'b0};
        dbl_c      = (dbl > {1'b0, hi}) ? hi : dbl[W-1:0];
        hlf        = adapt_eff >> 1;
        hlf_c      = (hlf < lo) ? lo : hlf;
        twice      = {adapt_eff, 1'b0};
        short_idle = (end_len < adapt_eff);
        long_idle  = ({1'b0, end_len} >= twice);
        if (short_idle)     next_tau = dbl_c;
        else if (long_idle) next_tau = hlf_c;
        else                next_tau = adapt_eff;
    end

    // Purpose: hold the adaptive timeout, seeded from the fixed value outside adaptive mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tau_reg <= FLOOR;
        end else if (mode_q != MODE_ADAPT) begin
            tau_reg <= fixed_tau;
        end else if (end_valid) begin
            tau_reg <= next_tau;
        end
    end

    // Purpose: pick the timeout in effect for the selected mode.
    always_comb begin
        unique case (mode_q)
            MODE_ADAPT:  tau_eff = adapt_eff;
            MODE_DEVDEP: tau_eff = lo;
            default:     tau_eff = fixed_tau;
        endcase
    end
endmodule

// File: rtl/idle_timeout_pm.sv
`timescale 1ns/1ps
// Module: power-state controller for one device with an idle timeout.
// Walks WORK -> IDLE -> SHUTDOWN -> SLEEP -> WAKEUP -> WORK. Shutdown and
// wake-up intervals always run to completion; activity meanwhile is held
// in one pending flag. Assumes configuration is static-or-slow; latencies
// are captured when an interval starts.
module idle_timeout_pm
    import pm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy_i,
    input  logic             req_i,
    input  logic [1:0]       mode_i,
    input  logic [CNT_W-1:0] cfg_tau_i,
    input  logic [CNT_W-1:0] cfg_tbe_i,
    input  logic [CNT_W-1:0] cfg_tau_max_i,
    input  logic [LAT_W-1:0] cfg_tsd_i,
    input  logic [LAT_W-1:0] cfg_twu_i,
    output logic [2:0]       pstate_o,
    output logic             ready_o,
    output logic             pending_o,
    output logic [CNT_W-1:0] tau_o
);
    pstate_e          state_q, state_d;
    logic             pend_q;
    logic             wake_evt;
    logic [CNT_W-1:0] idle_len;
    logic [CNT_W:0]   len_inc;
    logic [CNT_W-1:0] tau_eff;
    logic             meter_start, meter_run;
    logic             lat_load, lat_tick, lat_last;
    logic [LAT_W-1:0] lat_val;
    logic             end_valid;

    pm_idle_meter #(.W(CNT_W)) u_meter (
        .clk   (clk),
        .rst_n (rst_n),
        .start (meter_start),
        .run   (meter_run),
        .len   (idle_len)
    );

    pm_latency_timer #(.W(LAT_W)) u_lat (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (lat_load),
        .load_val (lat_val),
        .tick     (lat_tick),
        .last     (lat_last)
    );

    pm_timeout_adapt #(.W(CNT_W)) u_adapt (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode_i),
        .cfg_tau   (cfg_tau_i),
        .cfg_tbe   (cfg_tbe_i),
        .cfg_max   (cfg_tau_max_i),
        .end_valid (end_valid),
        .end_len   (idle_len),
        .tau_eff   (tau_eff)
    );

    // Purpose: activity or a request seen this cycle.
    always_comb wake_evt = busy_i | req_i;

    // Purpose: next-state logic and control strobes for the helpers.
    always_comb begin
        state_d     = state_q;
        meter_start = 1'b0;
        meter_run   = 1'b0;
        lat_load    = 1'b0;
        lat_val     = cfg_tsd_i;
        lat_tick    = 1'b0;
        end_valid   = 1'b0;
        len_inc     = {1'b0, idle_len} + (CNT_W+1)'(1);
        unique case (state_q)
            PS_WORK: begin
                if (!wake_evt) begin
                    state_d     = PS_IDLE;
                    meter_start = 1'b1;
                end
            end
            PS_IDLE: begin
                if (wake_evt) begin
                    state_d   = PS_WORK;
                    end_valid = 1'b1;
                end else begin
                    meter_run = 1'b1;
                    if (len_inc >= {1'b0, tau_eff}) begin
                        state_d  = PS_SHUT;
                        lat_load = 1'b1;
                        lat_val  = cfg_tsd_i;
                    end
                end
            end
            PS_SHUT: begin
                meter_run = 1'b1;
                if (lat_last) state_d = PS_SLEEP;
                else          lat_tick = 1'b1;
            end
            PS_SLEEP: begin
                if (pend_q) begin
                    state_d   = PS_WAKE;
                    lat_load  = 1'b1;
                    lat_val   = cfg_twu_i;
                    end_valid = 1'b1;
                end else begin
                    meter_run = 1'b1;
                end
            end
            PS_WAKE: begin
                if (lat_last) state_d = PS_WORK;
                else          lat_tick = 1'b1;
            end
            default: state_d = PS_WORK;
        endcase
    end

    // Purpose: power-state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_WORK;
        else        state_q <= state_d;
    end

    // Purpose: single pending flag, set while not ready, cleared once serving.
    always_ff @(posedge clk) begin
        if (!rst_n)                pend_q <= 1'b0;
        else if (state_q == PS_WORK) pend_q <= 1'b0;
        else if (wake_evt)         pend_q <= 1'b1;
    end

    // Purpose: drive the outputs.
    always_comb begin
        pstate_o  = state_q;
        ready_o   = (state_q == PS_WORK);
        pending_o = pend_q;
        tau_o     = tau_eff;
    end
endmodule

// File: rtl/idle_timeout_pm_chk.sv
`timescale 1ns/1ps
// Module: property checker for idle_timeout_pm, attached by bind.
// Assumes: observes ports only; reset is synchronous active-low.
module idle_timeout_pm_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy_i,
    input logic             req_i,
    input logic [1:0]       mode_i,
    input logic [CNT_W-1:0] cfg_tau_i,
    input logic [CNT_W-1:0] cfg_tbe_i,
    input logic [CNT_W-1:0] cfg_tau_max_i,
    input logic [2:0]       pstate_o,
    input logic             ready_o,
    input logic             pending_o,
    input logic [CNT_W-1:0] tau_o
);
    p_work_to_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !busy_i && !req_i) |=> (pstate_o == 3'd1));

    p_idle_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate_o == 3'd1 && (busy_i || req_i)) |=> (pstate_o == 3'd0));

    p_shut_no_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate_o == 3'd2) |=> (pstate_o == 3'd2 || pstate_o == 3'd3));

    p_sleep_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate_o == 3'd3 && !pending_o) |=> (pstate_o == 3'd3));

    p_wake_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate_o == 3'd4) |=> (pstate_o == 3'd4 || pstate_o == 3'd0));

    p_pending_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> !pending_o);

    p_fixed_tau_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd0 && cfg_tau_i >= CNT_W'(2)) |-> (tau_o == cfg_tau_i));

    p_adapt_bounds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd1 && cfg_tbe_i >= CNT_W'(2) && cfg_tau_max_i >= cfg_tbe_i)
        |-> (tau_o >= cfg_tbe_i && tau_o <= cfg_tau_max_i));
endmodule

bind idle_timeout_pm idle_timeout_pm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy_i        (busy_i),
    .req_i         (req_i),
    .mode_i        (mode_i),
    .cfg_tau_i     (cfg_tau_i),
    .cfg_tbe_i     (cfg_tbe_i),
    .cfg_tau_max_i (cfg_tau_max_i),
    .pstate_o      (pstate_o),
    .ready_o       (ready_o),
    .pending_o     (pending_o),
    .tau_o         (tau_o)
);

// File: tb/idle_timeout_pm_tb.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random traffic, checked each
// cycle against a bench model written from the requirements.
module idle_timeout_pm_tb;
    localparam int CW = 16;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          busy_i = 1'b1, req_i = 1'b0;
    logic [1:0]    mode_i = 2'd0;
    logic [CW-1:0] cfg_tau_i = 16'd5, cfg_tbe_i = 16'd3, cfg_tau_max_i = 16'd32;
    logic [LW-1:0] cfg_tsd_i = 8'd3, cfg_twu_i = 8'd2;
    logic [2:0]    pstate_o;
    logic          ready_o, pending_o;
    logic [CW-1:0] tau_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    idle_timeout_pm #(.CNT_W(CW), .LAT_W(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .req_i(req_i),
        .mode_i(mode_i), .cfg_tau_i(cfg_tau_i), .cfg_tbe_i(cfg_tbe_i),
        .cfg_tau_max_i(cfg_tau_max_i), .cfg_tsd_i(cfg_tsd_i),
        .cfg_twu_i(cfg_twu_i), .pstate_o(pstate_o), .ready_o(ready_o),
        .pending_o(pending_o), .tau_o(tau_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- bench model ----------------
    int m_st = 0, m_len = 0, m_lat = 1, m_reg = 2;
    bit m_pend = 0;

    function automatic int f_lo();  return (int'(cfg_tbe_i) > 2) ? int'(cfg_tbe_i) : 2; endfunction
    function automatic int f_hi();  return (int'(cfg_tau_max_i) < f_lo()) ? f_lo() : int'(cfg_tau_max_i); endfunction
    function automatic int f_fix(); return (int'(cfg_tau_i) > 2) ? int'(cfg_tau_i) : 2; endfunction
    function automatic int f_aeff(input int r);
        if (r < f_lo()) return f_lo();
        if (r > f_hi()) return f_hi();
        return r;
    endfunction
    function automatic int f_eff(input int r);
        if (mode_i == 2'd1) return f_aeff(r);
        if (mode_i == 2'd2) return f_lo();
        return f_fix();
    endfunction
    function automatic int f_retune(input int r, input int len);
        int t = f_aeff(r);
        if (len < t)      return (2*t > f_hi()) ? f_hi() : 2*t;
        if (len >= 2*t)   return ((t/2) < f_lo()) ? f_lo() : t/2;
        return t;
    endfunction
    function automatic int f_sat(input int v); return (v > 65535) ? 65535 : v; endfunction

    always @(posedge clk) begin
        int st, len, lat, rg; bit pd, ev, endv;
        if (!rst_n) begin
            m_st = 0; m_len = 0; m_lat = 1; m_reg = 2; m_pend = 0;
        end else begin
            st = m_st; len = m_len; lat = m_lat; rg = m_reg; pd = m_pend;
            ev = busy_i | req_i; endv = 0;
            case (m_st)
                0: if (!ev) begin st = 1; len = 1; end
                1: if (ev) begin st = 0; endv = 1; end
                   else begin
                       len = f_sat(m_len + 1);
                       if (m_len + 1 >= f_eff(m_reg)) begin
                           st = 2; lat = (cfg_tsd_i == 0) ? 1 : int'(cfg_tsd_i);
                       end
                   end
                2: begin len = f_sat(m_len + 1);
                       if (m_lat <= 1) st = 3; else lat = m_lat - 1; end
                3: if (m_pend) begin st = 4; endv = 1;
                       lat = (cfg_twu_i == 0) ? 1 : int'(cfg_twu_i); end
                   else len = f_sat(m_len + 1);
                default: if (m_lat <= 1) st = 0; else lat = m_lat - 1;
            endcase
            if (mode_i != 2'd1) rg = f_fix();
            else if (endv)      rg = f_retune(m_reg, m_len);
            pd = (m_st == 0) ? 1'b0 : (m_pend | ev);
            m_st = st; m_len = len; m_lat = lat; m_reg = rg; m_pend = pd;
        end
    end

    // Lockstep comparison, sampled 1 ns after the edge.
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            chk((m_st >= 3) ? "R5 state" : (m_st == 2) ? "R4 state" : "R2 state",
                int'(pstate_o), m_st);
            chk("R6 ready", int'(ready_o), (m_st == 0) ? 1 : 0);
            chk("R7 pending", int'(pending_o), int'(m_pend));
            chk((mode_i == 2'd1) ? "R9 tau" : "R8 tau", int'(tau_o), f_eff(m_reg));
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic wait_state(input int s);
        for (int i = 0; i < 400; i++) begin
            if (int'(pstate_o) == s) return;
            @(negedge clk);
        end
    endtask

    task automatic long_sleep_cycle(input int expect_tau, input string tag);
        busy_i = 1'b0;
        @(negedge clk);
        wait_state(3);
        repeat (70) @(negedge clk);
        req_i = 1'b1; busy_i = 1'b1;
        @(negedge clk);
        req_i = 1'b0;
        wait_state(0);
        @(negedge clk);
        chk(tag, int'(tau_o), expect_tau);
    endtask

    task automatic short_idle(input int expect_tau, input string tag);
        busy_i = 1'b0;
        repeat (3) @(negedge clk);
        busy_i = 1'b1;
        @(negedge clk);
        chk(tag, int'(tau_o), expect_tau);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 state", int'(pstate_o), 0);
        chk("R1 ready", int'(ready_o), 1);
        chk("R1 pending", int'(pending_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2: fixed tau=5 -> IDLE after 4 low edges, SHUTDOWN at the 5th
        busy_i = 1'b0;
        repeat (4) @(negedge clk);
        chk("R2 idle before timeout", int'(pstate_o), 1);
        @(negedge clk);
        chk("R2 shutdown at timeout", int'(pstate_o), 2);
        // R4: activity during shutdown does not abort it (tsd=3)
        busy_i = 1'b1;
        repeat (2) @(negedge clk);
        chk("R4 shutdown continues", int'(pstate_o), 2);
        @(negedge clk);
        chk("R4 sleep after shutdown", int'(pstate_o), 3);
        chk("R7 pending from activity", int'(pending_o), 1);
        // R5: wake-up of twu=2 cycles then WORK
        @(negedge clk);
        chk("R5 wakeup", int'(pstate_o), 4);
        @(negedge clk);
        chk("R5 wakeup second cycle", int'(pstate_o), 4);
        @(negedge clk);
        chk("R5 work after wakeup", int'(pstate_o), 0);

        // R3: busy during IDLE returns to WORK
        busy_i = 1'b0;
        repeat (2) @(negedge clk);
        busy_i = 1'b1;
        @(negedge clk);
        chk("R3 idle exit", int'(pstate_o), 0);

        // R7: several requests while not ready -> one wake-up
        busy_i = 1'b0;
        wait_state(3);
        req_i = 1'b1; @(negedge clk); req_i = 1'b0;
        wait_state(4);
        req_i = 1'b1; busy_i = 1'b1; @(negedge clk); req_i = 1'b0;
        wait_state(0);
        @(negedge clk);
        chk("R7 pending cleared", int'(pending_o), 0);
        repeat (5) @(negedge clk);
        chk("R7 single wakeup", int'(pstate_o), 0);

        // R8 / R12: timeout sources
        cfg_tau_i = 16'd1; @(negedge clk);
        chk("R8 fixed floor", int'(tau_o), 2);
        mode_i = 2'd2; cfg_tbe_i = 16'd6; @(negedge clk);
        chk("R8 device tau", int'(tau_o), 6);
        cfg_tbe_i = 16'd1; @(negedge clk);
        chk("R8 device floor", int'(tau_o), 2);
        mode_i = 2'd3; cfg_tau_i = 16'd9; @(negedge clk);
        chk("R12 reserved mode fixed", int'(tau_o), 9);

        // R11 / R9 / R10: adaptive walk
        mode_i = 2'd0; cfg_tau_i = 16'd8; cfg_tbe_i = 16'd3; cfg_tau_max_i = 16'd32;
        @(negedge clk);
        mode_i = 2'd1; @(negedge clk);
        chk("R11 adaptive seed", int'(tau_o), 8);
        short_idle(16, "R9 double");
        short_idle(32, "R9 double to ceiling");
        short_idle(32, "R9 clamp at ceiling");
        long_sleep_cycle(16, "R10 halve");
        long_sleep_cycle(8, "R10 halve again");
        long_sleep_cycle(4, "R10 halve to four");
        long_sleep_cycle(3, "R10 floor at break-even");

        // Random traffic
        begin
            int run = 0;
            for (int c = 0; c < 6000; c++) begin
                if (c % 400 == 399) begin
                    mode_i = 2'($urandom_range(0, 3));
                    cfg_tau_i = 16'($urandom_range(1, 20));
                    cfg_tbe_i = 16'($urandom_range(1, 8));
                    cfg_tau_max_i = 16'($urandom_range(4, 40));
                    cfg_tsd_i = 8'($urandom_range(0, 5));
                    cfg_twu_i = 8'($urandom_range(0, 5));
                end
                if (run == 0) begin
                    busy_i = ~busy_i;
                    run = busy_i ? $urandom_range(1, 8) : $urandom_range(1, 60);
                end
                run--;
                req_i = ($urandom_range(0, 39) == 0);
                @(negedge clk);
            end
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule